// File: doc/BRIEF.md
# Message Interrupt Pending Tracker

This block keeps the state of a large population of message-signalled interrupts on the processor side of an interrupt router. An interrupt is either idle or pending, and its state is a single bit in a memory-held pending table. Its urgency and mask come from a one-byte-per-interrupt configuration table. The routing unit delivers interrupt numbers on a single-cycle strobe. The tracker records each one and presents the most urgent enabled pending interrupt to a processor acknowledge handshake. An acknowledge clears the pending bit at once. No active state exists.

A small cache holds newly pending interrupts. When the cache is full, a new arrival is recorded straight into the table. A low-power request drains every cached entry into the table, and the block answers it only when the cache is empty. A programmable base value selects which region of the modelled pending memory serves as the table. Software writes the configuration bytes through a dedicated port. The tracker only reads them.

Top module: `msgirq_pend_tracker`

## Requirements
- R1: After reset, no interrupt is pending, `irq_valid` is 0 and `lp_ack` is 0.
- R2: An arrival taken while `track_en` is 1 becomes pending. From the next cycle it is presented with `irq_id` equal to its number and `irq_prio` equal to configuration bits [7:2] followed by two zero bits.
- R3: While `track_en` is 0, arrivals are ignored and leave the pending state unchanged.
- R4: Among the enabled pending interrupts, the one with the numerically lowest priority field is presented. On equal priority, the lowest interrupt number wins.
- R5: Configuration bit 0 is the enable. A pending interrupt whose enable bit is 0 is never presented, but it stays pending. Setting the bit later presents it.
- R6: An acknowledge (`irq_ack` while `irq_valid`) clears the presented interrupt's pending bit in that cycle. The next cycle shows the next candidate. An arrival of that same number in the acknowledge cycle leaves it pending.
- R7: An arrival for an interrupt that is already pending merges into the existing bit, so a single acknowledge clears it.
- R8: Arrivals beyond the cache depth are written to the pending table. Every one of them is later presented in order.
- R9: While `lp_req` is 1, one cached entry per cycle is written to the table. `lp_ack` rises once the cache is empty, and the pending state is preserved.
- R10: The pending table is the region of pending memory selected by the base value. Changing the base shows that region's bits, and changing it back restores the earlier state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| track_en | input | 1 | Global tracking enable |
| in_valid | input | 1 | Arrival strobe from the routing unit |
| in_id | input | IDW | Arriving interrupt number |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | IDW | Interrupt number whose configuration byte is written |
| cfg_wdata | input | 8 | Configuration byte: [7:2] priority, [1] reserved, [0] enable |
| base_we | input | 1 | Pending-table base write strobe |
| base_wdata | input | BW | New pending-table region select |
| lp_req | input | 1 | Low-power request |
| lp_ack | output | 1 | Low-power acknowledge, cache drained |
| irq_valid | output | 1 | An enabled pending interrupt is presented |
| irq_id | output | IDW | Presented interrupt number |
| irq_prio | output | 8 | Presented priority, low two bits zero |
| irq_ack | input | 1 | Processor acknowledge of the presented interrupt |

## Verification
Every output is a combinational function of registered state. The effect of an arrival, acknowledge, configuration write or base write therefore shows at the outputs one clock edge after the input is sampled. The bench drives inputs on the falling edge, holds them across one rising edge, and compares outputs at the next falling edge. A drain takes one edge per cached entry. The bench waits the cache depth plus one edges before it expects `lp_ack`.

// File: rtl/msgirq_pkg.sv
// Shared types for the message interrupt pending tracker.
// Assumes the configuration byte layout below is fixed by software.
package msgirq_pkg;
    typedef struct packed {
        logic [5:0] prio;   // lower value = more urgent
        logic       rsvd;   // unused, read as stored
        logic       en;     // 1 = may be presented
    } cfg_byte_t;
endpackage

// File: rtl/msgirq_cfg_table.sv
// Modelled configuration memory: one byte per interrupt, written only through
// the software port. Assumes the tracker consumes it read-only.
module msgirq_cfg_table
    import msgirq_pkg::*;
#(
    parameter int N   = 64,
    parameter int IDW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [IDW-1:0]  waddr,
    input  logic [7:0]      wdata,
    output cfg_byte_t       cfg [N]
);
    cfg_byte_t mem [N];

    // Software byte writes; everything starts disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= cfg_byte_t'(wdata);
        end
    end

    // Expose the whole table to the selector.
    always_comb begin
        for (int i = 0; i < N; i++) cfg[i] = mem[i];
    end
endmodule

// File: rtl/msgirq_pend_table.sv
// Modelled pending memory of N*BANKS bits. The base value selects which N-bit
// region acts as the pending table. Assumes N and BANKS are powers of two.
// When a set and a clear hit the same bit in one cycle, the set wins.
module msgirq_pend_table #(
    parameter int N     = 64,
    parameter int BANKS = 2,
    parameter int IDW   = $clog2(N),
    parameter int BW    = $clog2(BANKS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [BW-1:0]   base,
    input  logic            set_a_en,
    input  logic [IDW-1:0]  set_a_id,
    input  logic            set_b_en,
    input  logic [IDW-1:0]  set_b_id,
    input  logic            clr_en,
    input  logic [IDW-1:0]  clr_id,
    output logic [N-1:0]    window
);
    localparam int BITS = N * BANKS;
    localparam int AW   = BW + IDW;

    logic [BITS-1:0] bits_q;

    // Clear on acknowledge first, then apply the two set ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            if (clr_en)   bits_q[{base, clr_id}]   <= 1'b0;
            if (set_a_en) bits_q[{base, set_a_id}] <= 1'b1;
            if (set_b_en) bits_q[{base, set_b_id}] <= 1'b1;
        end
    end

    // Read out the region that the base value selects.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            window[i] = bits_q[{base, IDW'(i)}];
        end
    end

    // An overflow write must be visible in the table on the next cycle.
    assert_set_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_a_en |=> bits_q[AW'($past({base, set_a_id}))]);
endmodule

// File: rtl/msgirq_pend_cache.sv
// Small cache of pending interrupt numbers. It inserts into the lowest free
// slot, clears the slot that matches an acknowledge, and drains the lowest
// valid slot when a flush is requested. Assumes the caller inserts only when
// the cache is not full and never inserts a number that is already cached.
module msgirq_pend_cache #(
    parameter int N     = 64,
    parameter int DEPTH = 4,
    parameter int IDW   = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ins_en,
    input  logic [IDW-1:0]  ins_id,
    input  logic            clr_en,
    input  logic [IDW-1:0]  clr_id,
    input  logic            flush_en,
    output logic            flush_fire,
    output logic [IDW-1:0]  flush_id,
    output logic            full,
    output logic            empty,
    output logic [N-1:0]    hit_vec
);
    localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] valid_q;
    logic [IDW-1:0]   ids_q [DEPTH];
    logic [SW-1:0]    free_slot;
    logic [SW-1:0]    drain_slot;

    // Find the lowest free slot and the lowest occupied slot.
    always_comb begin
        free_slot  = '0;
        drain_slot = '0;
        for (int s = DEPTH - 1; s >= 0; s--) begin
            if (!valid_q[s]) free_slot  = SW'(s);
            if (valid_q[s])  drain_slot = SW'(s);
        end
    end

    assign full       = &valid_q;
    assign empty      = ~|valid_q;
    assign flush_fire = flush_en && !empty;
    assign flush_id   = ids_q[drain_slot];

    // Expand the cached numbers into a per-interrupt pending view.
    always_comb begin
        hit_vec = '0;
        for (int s = 0; s < DEPTH; s++) begin
            if (valid_q[s]) hit_vec[ids_q[s]] = 1'b1;
        end
    end

    // Slot updates: acknowledge clear, then drain, then insert.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int s = 0; s < DEPTH; s++) ids_q[s] <= '0;
        end else begin
            for (int s = 0; s < DEPTH; s++) begin
                if (clr_en && valid_q[s] && ids_q[s] == clr_id) valid_q[s] <= 1'b0;
            end
            if (flush_fire) valid_q[drain_slot] <= 1'b0;
            if (ins_en) begin
                valid_q[free_slot] <= 1'b1;
                ids_q[free_slot]   <= ins_id;
            end
        end
    end

    // The caller must never insert into a full cache.
    assert_insert_has_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |-> !full);

    // A drain step without an insert or clear removes exactly one entry.
    assert_drain_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_fire && !ins_en && !clr_en) |=>
            $countones(valid_q) == $past($countones(valid_q)) - 1);
endmodule

// File: rtl/msgirq_prio_select.sv
// Combinational selector. It picks the enabled pending interrupt with the
// lowest priority value, and the lowest number on a tie. Assumes the pending
// view already merges the cache and the table.
module msgirq_prio_select
    import msgirq_pkg::*;
#(
    parameter int N   = 64,
    parameter int IDW = $clog2(N)
) (
    input  logic [N-1:0]    pend,
    input  cfg_byte_t       cfg [N],
    output logic            found,
    output logic [IDW-1:0]  best_id,
    output logic [5:0]      best_prio
);
    // Ascending scan; only a strictly better priority replaces the holder.
    always_comb begin
        found     = 1'b0;
        best_id   = '0;
        best_prio = '1;
        for (int i = 0; i < N; i++) begin
            if (pend[i] && cfg[i].en && (!found || cfg[i].prio < best_prio)) begin
                found     = 1'b1;
                best_id   = IDW'(i);
                best_prio = cfg[i].prio;
            end
        end
    end
endmodule

// File: rtl/msgirq_pend_tracker.sv
// Top of the message interrupt pending tracker. It accepts arrivals from the
// routing unit, keeps them in the cache or the pending table, presents the
// most urgent enabled one, clears it on acknowledge, and drains the cache on
// a low-power request. Assumes software changes the base only with an empty cache.
module msgirq_pend_tracker
    import msgirq_pkg::*;
#(
    parameter int N           = 64,
    parameter int CACHE_DEPTH = 4,
    parameter int BANKS       = 2,
    parameter int IDW         = $clog2(N),
    parameter int BW          = $clog2(BANKS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            track_en,
    input  logic            in_valid,
    input  logic [IDW-1:0]  in_id,
    input  logic            cfg_we,
    input  logic [IDW-1:0]  cfg_addr,
    input  logic [7:0]      cfg_wdata,
    input  logic            base_we,
    input  logic [BW-1:0]   base_wdata,
    input  logic            lp_req,
    output logic            lp_ack,
    output logic            irq_valid,
    output logic [IDW-1:0]  irq_id,
    output logic [7:0]      irq_prio,
    input  logic            irq_ack
);
    cfg_byte_t       cfg [N];
    logic [BW-1:0]   base_q;
    logic [N-1:0]    window;
    logic [N-1:0]    hit_vec;
    logic [N-1:0]    pend_vec;
    logic            cache_full, cache_empty;
    logic            flush_fire;
    logic [IDW-1:0]  flush_id;
    logic            found;
    logic [IDW-1:0]  best_id;
    logic [5:0]      best_prio;
    logic            ack_fire, in_fire, already, new_arr, to_cache, to_table;

    // Pending-table base register.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (base_we) base_q <= base_wdata;
    end

    // Arrival steering: merge, cache, or overflow into the table.
    always_comb begin
        ack_fire = irq_ack && irq_valid;
        in_fire  = track_en && in_valid;
        already  = pend_vec[in_id] && !(ack_fire && irq_id == in_id);
        new_arr  = in_fire && !already;
        to_cache = new_arr && !cache_full && !lp_req;
        to_table = new_arr && !to_cache;
    end

    assign pend_vec = window | hit_vec;

    msgirq_cfg_table #(.N(N), .IDW(IDW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr),
        .wdata(cfg_wdata), .cfg(cfg)
    );

    msgirq_pend_table #(.N(N), .BANKS(BANKS), .IDW(IDW), .BW(BW)) u_table (
        .clk(clk), .rst_n(rst_n), .base(base_q),
        .set_a_en(to_table), .set_a_id(in_id),
        .set_b_en(flush_fire), .set_b_id(flush_id),
        .clr_en(ack_fire), .clr_id(irq_id),
        .window(window)
    );

    msgirq_pend_cache #(.N(N), .DEPTH(CACHE_DEPTH), .IDW(IDW)) u_cache (
        .clk(clk), .rst_n(rst_n),
        .ins_en(to_cache), .ins_id(in_id),
        .clr_en(ack_fire), .clr_id(irq_id),
        .flush_en(lp_req && !ack_fire),
        .flush_fire(flush_fire), .flush_id(flush_id),
        .full(cache_full), .empty(cache_empty),
        .hit_vec(hit_vec)
    );

    msgirq_prio_select #(.N(N), .IDW(IDW)) u_sel (
        .pend(pend_vec), .cfg(cfg),
        .found(found), .best_id(best_id), .best_prio(best_prio)
    );

    assign irq_valid = found;
    assign irq_id    = best_id;
    assign irq_prio  = {best_prio, 2'b00};
    assign lp_ack    = lp_req && cache_empty;

    // An acknowledge without a same-number arrival leaves the number idle.
    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && !(in_fire && in_id == irq_id) && !base_we) |=>
            !pend_vec[$past(irq_id)]);

    // With tracking off and no acknowledge, the pending state does not move.
    assert_disabled_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!track_en && !ack_fire && !base_we) |=> pend_vec == $past(pend_vec));

    // The selector must only offer interrupts whose enable bit is set.
    assert_present_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> cfg[irq_id].en);
endmodule

// File: tb/msgirq_pend_tracker_test.sv
module msgirq_pend_tracker_test;
    localparam int N = 64, DEPTH = 4, IDW = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic track_en = 1'b0, in_valid = 1'b0, cfg_we = 1'b0, base_we = 1'b0;
    logic lp_req = 1'b0, irq_ack = 1'b0;
    logic [IDW-1:0] in_id = '0, cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [0:0] base_wdata = '0;
    logic lp_ack, irq_valid;
    logic [IDW-1:0] irq_id;
    logic [7:0] irq_prio;

    int checks = 0, failures = 0, cyc_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    msgirq_pend_tracker #(.N(N), .CACHE_DEPTH(DEPTH), .BANKS(2)) uut (
        .clk(clk), .rst_n(rst_n), .track_en(track_en), .in_valid(in_valid),
        .in_id(in_id), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .base_we(base_we), .base_wdata(base_wdata), .lp_req(lp_req), .lp_ack(lp_ack),
        .irq_valid(irq_valid), .irq_id(irq_id), .irq_prio(irq_prio), .irq_ack(irq_ack)
    );

    // Stimulus vector: arrival, acknowledge, and the expected presentation.
    typedef struct packed {
        bit       iv;
        bit [5:0] id;
        bit       ack;
        bit       ev;
        bit [5:0] eid;
        bit [7:0] ep;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 6'd3,  1'b0, 1'b1, 6'd3,  8'hA0},  // R2 single arrival
        '{1'b1, 6'd20, 1'b0, 1'b1, 6'd20, 8'h14},  // R4 more urgent wins
        '{1'b1, 6'd10, 1'b0, 1'b1, 6'd10, 8'h14},  // R4 tie -> lower number
        '{1'b1, 6'd10, 1'b0, 1'b1, 6'd10, 8'h14},  // R7 duplicate merges
        '{1'b0, 6'd0,  1'b1, 1'b1, 6'd20, 8'h14},  // R7/R6 one ack clears 10
        '{1'b0, 6'd0,  1'b1, 1'b1, 6'd3,  8'hA0},  // R6 next candidate
        '{1'b1, 6'd30, 1'b0, 1'b1, 6'd3,  8'hA0},  // R5 masked arrival hidden
        '{1'b0, 6'd0,  1'b1, 1'b0, 6'd0,  8'h00}   // R5 only masked left
    };

    task automatic check_out(string tag, bit ev, int eid, int ep);
        checks++;
        if (irq_valid !== ev || (ev && (irq_id !== IDW'(eid) || irq_prio !== 8'(ep)))) begin
            failures++;
            $display("FAIL %s: got valid=%0b id=%0d prio=%0h, expected valid=%0b id=%0d prio=%0h",
                     tag, irq_valid, irq_id, irq_prio, ev, eid, ep);
        end
    endtask

    task automatic check_bit(string tag, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %0b, expected %0b", tag, got, exp);
        end
    endtask

    // One cycle with the given arrival/acknowledge, checked at the next falling edge.
    task automatic step(bit iv, int id, bit ack);
        in_valid = iv;
        in_id    = IDW'(id);
        irq_ack  = ack;
        @(negedge clk);
        in_valid = 1'b0;
        irq_ack  = 1'b0;
    endtask

    task automatic cfg_write(int addr, int data);
        cfg_we    = 1'b1;
        cfg_addr  = IDW'(addr);
        cfg_wdata = 8'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic base_write(int b);
        base_we    = 1'b1;
        base_wdata = 1'(b);
        @(negedge clk);
        base_we = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failure.
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 20000 && !done) begin
            failures++;
            $display("FAIL watchdog: got timeout, expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check_bit("R1 irq_valid", irq_valid, 1'b0);
        check_bit("R1 lp_ack", lp_ack, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R1 after release", irq_valid, 1'b0);

        // Configuration: all enabled at priority 32, then a few overrides.
        for (int i = 0; i < N; i++) cfg_write(i, 8'h81);
        cfg_write(10, 8'h15);
        cfg_write(20, 8'h15);
        cfg_write(3,  8'hA1);
        cfg_write(30, 8'h04);
        track_en = 1'b1;

        for (int v = 0; v < 8; v++) begin
            step(VECS[v].iv, VECS[v].id, VECS[v].ack);
            check_out($sformatf("R2/R4/R5/R6/R7 vector %0d", v), VECS[v].ev, VECS[v].eid, VECS[v].ep);
        end

        // R5: enabling the masked pending interrupt presents it.
        cfg_write(30, 8'h05);
        check_out("R5 re-enable", 1'b1, 30, 8'h04);
        step(0, 0, 1);
        check_out("R6 ack of 30", 1'b0, 0, 0);

        // R3: arrivals ignored while tracking is off.
        track_en = 1'b0;
        step(1, 7, 0);
        check_out("R3 disabled arrival", 1'b0, 0, 0);
        track_en = 1'b1;
        @(negedge clk);
        check_out("R3 still idle", 1'b0, 0, 0);

        // R8: six arrivals into a four-entry cache, all presented in order.
        for (int k = 40; k < 46; k++) begin
            step(1, k, 0);
            check_out("R8 fill", 1'b1, 40, 8'h80);
        end
        for (int k = 41; k < 46; k++) begin
            step(0, 0, 1);
            check_out("R8 drain order", 1'b1, k, 8'h80);
        end
        step(0, 0, 1);
        check_out("R8 all cleared", 1'b0, 0, 0);

        // R6: same-number arrival in the acknowledge cycle stays pending.
        step(1, 50, 0);
        check_out("R2 arrival 50", 1'b1, 50, 8'h80);
        step(1, 50, 1);
        check_out("R6 rearrival wins", 1'b1, 50, 8'h80);
        step(0, 0, 1);
        check_out("R6 cleared", 1'b0, 0, 0);

        // R9: low-power drain of two cached entries.
        step(1, 11, 0);
        step(1, 12, 0);
        lp_req = 1'b1;
        #1;
        check_bit("R9 ack waits for drain", lp_ack, 1'b0);
        repeat (DEPTH + 1) @(negedge clk);
        check_bit("R9 ack after drain", lp_ack, 1'b1);
        check_out("R9 state kept", 1'b1, 11, 8'h80);
        lp_req = 1'b0;
        @(negedge clk);
        check_bit("R9 ack drops", lp_ack, 1'b0);

        // R10: base selects the pending region.
        base_write(1);
        check_out("R10 other region empty", 1'b0, 0, 0);
        base_write(0);
        check_out("R10 region restored", 1'b1, 11, 8'h80);
        step(0, 0, 1);
        check_out("R6 next after 11", 1'b1, 12, 8'h80);
        step(0, 0, 1);
        check_out("R6 table empty", 1'b0, 0, 0);

        finish_run();
    end
endmodule